// File: doc/BRIEF.md
# Shift-Register Float Noise Source

This block turns a 32-bit linear feedback shift register into a stream of IEEE-754 single-precision words whose magnitudes stay within a narrow band, roughly 0.125 up to just under 8. A start request loads a 32-bit seed pattern. The block then emits a fixed number of words, one per clock, each with a single-cycle write strobe meant for a downstream FIFO.

Each step shifts the register right by one bit. The new top bit is the XOR of four fixed tap positions. Sign and mantissa of the shifted word pass straight through to the output. Only its exponent field is folded into a small set of values by bit masking. The register keeps its unfolded value, so the sequence of register states depends only on the seed.

After the last word the block stays in a finished state for as long as the start request is held. It returns to idle once start is released.

Top module: `lfsr_float_gen`

## Requirements
- R1: One step computes next = {s[0]^s[1]^s[21]^s[31], s[31:1]} from register state s.
- R2: If bit 30 of the shifted word (exponent bit 7) is 1, the emitted exponent (bits 30:23) is the shifted exponent ANDed with 8'b1000_0001, giving 128 or 129.
- R3: If bit 30 of the shifted word is 0, the emitted exponent is the shifted exponent ORed with 8'b0111_1100, giving 124 to 127.
- R4: The emitted sign (bit 31) and mantissa (bits 22:0) equal those of the shifted word.
- R5: Each step starts from the unmasked shifted state, not from the emitted word.
- R6: While idle, start high loads seed. The first word, which is the shaped result of one step from the seed, appears on wr_data with wr_en two clock edges after start is sampled. While idle with start low, nothing is written.
- R7: A run emits exactly RUN_LEN words (default 1024) on consecutive cycles, with wr_en high for one cycle per word and low afterwards.
- R8: Together with the last word, done rises and busy falls. done stays high while start is high. One edge after start is seen low, done and busy are both 0. busy and done are never high together.
- R9: Changes on start and seed during a run have no effect on the emitted stream.
- R10: An all-zero seed yields the word 32'h3E00_0000 for every word of the run.
- R11: In and just after reset, busy, done and wr_en are 0 and wr_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, sampled as a level |
| seed | input | 32 | Initial register pattern, taken when a run starts |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, waiting for start to drop |
| wr_en | output | 1 | One-cycle strobe per emitted word |
| wr_data | output | 32 | Emitted single-precision word |

## Verification
The assertions assume that reset is applied once and then held inactive, and that start and seed are synchronous to clk. The done-hold property also assumes that start is treated as a level and is not pulsed faster than the block can sample it. The bench changes every input only at falling edges and samples at falling edges, so each input is stable around the rising edge that reads it. It runs full-length streams from seeds that reach both exponent branches, the zero fixed point, and the all-ones and single-bit patterns. During one run it deliberately moves start and seed to show they are ignored.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_LSB = 23;
  localparam int EXP_W = 8;
  localparam logic [WORD_W-1:0] TAPS = 32'h8020_0003;
  localparam logic [EXP_W-1:0] HI_KEEP = 8'b1000_0001;
  localparam logic [EXP_W-1:0] LO_FORCE = 8'b0111_1100;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_e;

  // one right shift, feedback from the tap positions into the top bit
  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
    return {^(s & TAPS), s[WORD_W-1:1]};
  endfunction

  // fold an exponent into the narrow band
  function automatic logic [EXP_W-1:0] exp_fold(input logic [EXP_W-1:0] e);
    return e[EXP_W-1] ? (e & HI_KEEP) : (e | LO_FORCE);
  endfunction

  function automatic logic [WORD_W-1:0] shape_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[EXP_LSB +: EXP_W] = exp_fold(w[EXP_LSB +: EXP_W]);
    return r;
  endfunction
endpackage

// File: rtl/lfg_stepper.sv
module lfg_stepper
  import lfg_pkg::*;
(
  input  logic [WORD_W-1:0] cur_state,
  output logic [WORD_W-1:0] nxt_state,
  output logic [WORD_W-1:0] shaped
);
  always_comb begin
    nxt_state = lfsr_next(cur_state);
    shaped    = shape_word(nxt_state);
  end
endmodule

// File: rtl/lfg_sequencer.sv
module lfg_sequencer
  import lfg_pkg::*;
#(
  parameter int RUN_LEN = 1024
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   load_fire,
  output logic   step_fire,
  output logic   last_fire
);
  localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  phase_e phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign phase     = phase_q;
  assign load_fire = (phase_q == PH_IDLE) && start;
  assign step_fire = (phase_q == PH_RUN);
  assign last_fire = step_fire && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_RUN;
          cnt_q   <= '0;
        end
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_fire) phase_q <= PH_DONE;
        end
        PH_DONE: if (!start) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lfg_out_stage.sv
module lfg_out_stage
  import lfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [WORD_W-1:0] word_in,
  output logic              strobe,
  output logic [WORD_W-1:0] word_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe   <= 1'b0;
      word_out <= '0;
    end else begin
      strobe <= emit;
      if (emit) word_out <= word_in;
    end
  end
endmodule

// File: rtl/lfsr_float_gen.sv
module lfsr_float_gen
  import lfg_pkg::*;
#(
  parameter int RUN_LEN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] seed,
  output logic        busy,
  output logic        done,
  output logic        wr_en,
  output logic [31:0] wr_data
);
  phase_e phase;
  logic load_fire, step_fire, last_fire;
  logic [WORD_W-1:0] state_q, nxt_state, shaped;

  lfg_sequencer #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
    .load_fire(load_fire), .step_fire(step_fire), .last_fire(last_fire)
  );

  lfg_stepper u_step (
    .cur_state(state_q), .nxt_state(nxt_state), .shaped(shaped)
  );

  // register advances on the unmasked value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= '0;
    else if (load_fire) state_q <= seed;
    else if (step_fire) state_q <= nxt_state;
  end

  lfg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .emit(step_fire), .word_in(shaped),
    .strobe(wr_en), .word_out(wr_data)
  );

  assign busy = (phase == PH_RUN);
  assign done = (phase == PH_DONE);
endmodule

// File: rtl/lfg_checker.sv
module lfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] state_q,
  input logic        step_fire
);
  assert_feedback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (state_q[30:0] == $past(state_q[31:1])) &&
      (state_q[31] == ($past(state_q[0]) ^ $past(state_q[1]) ^ $past(state_q[21]) ^ $past(state_q[31]))));

  assert_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[30]) |-> (wr_data[29:24] == 6'd0));

  assert_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[30]) |-> (wr_data[29:25] == 5'b11111));

  // R4 / R5: emitted sign and mantissa track the unmasked register
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[31] == state_q[31]) && (wr_data[22:0] == state_q[22:0]));

  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state_q == 32'd0) |=> (state_q == 32'd0));
endmodule

bind lfsr_float_gen lfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_data(wr_data), .state_q(state_q), .step_fire(step_fire)
);

// File: tb/lfsr_float_gen_bench.sv
module lfsr_float_gen_bench;
  localparam int RUN_LEN = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] seed = '0;
  logic busy, done, wr_en;
  logic [31:0] wr_data;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  lfsr_float_gen #(.RUN_LEN(RUN_LEN)) u_lfsr_float_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .busy(busy), .done(done), .wr_en(wr_en), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference step, R1: parity of the tap bits shifted in at the top
  function automatic logic [31:0] m_step(input logic [31:0] s);
    return {s[0] ^ s[1] ^ s[21] ^ s[31], s[31:1]};
  endfunction

  // reference shaping, R2/R3 written arithmetically
  function automatic logic [31:0] m_shape(input logic [31:0] w);
    int e, ne;
    e = int'(w[30:23]);
    ne = (e >= 128) ? 128 + (e % 2) : 124 + (e % 4);
    return {w[31], 8'(ne), w[22:0]};
  endfunction

  task automatic run_seq(input logic [31:0] sd, input bit disturb);
    logic [31:0] m = sd;
    logic [31:0] ex;
    int got = 0;
    int cyc = 0;
    int errs = 0;
    @(negedge clk);
    seed = sd;
    start = 1'b1;
    while (got < RUN_LEN && cyc < RUN_LEN + 20) begin
      @(negedge clk);
      cyc++;
      if (wr_en) begin
        if (got == 0) chk(cyc == 2, "R6", "first word latency", 32'(cyc), 32'd2);
        m = m_step(m);  // R5: model advances on the unmasked state
        ex = m_shape(m);
        if (wr_data != ex) errs++;
        chk(wr_data[30:23] == ex[30:23], m[30] ? "R2" : "R3", "exponent", wr_data, ex);
        chk({wr_data[31], wr_data[22:0]} == {m[31], m[22:0]}, "R4", "sign/mantissa", wr_data, m);
        if (sd == 32'd0) chk(wr_data == 32'h3E00_0000, "R10", "zero seed word", wr_data, 32'h3E00_0000);
        got++;
        if (got == RUN_LEN) chk(done && !busy, "R8", "done with last word", {30'd0, busy, done}, 32'd1);
      end else if (got > 0) begin
        chk(1'b0, "R7", "gap in stream", 32'(got), 32'(RUN_LEN));
      end
      if (disturb) begin
        if (got == 100) begin start = 1'b0; seed = ~sd; end
        if (got == 300) begin start = 1'b1; seed = 32'h1234_5678; end
      end
    end
    chk(got == RUN_LEN, "R7", "word count", 32'(got), 32'(RUN_LEN));
    chk(errs == 0, "R5", "R1 stream mismatches", 32'(errs), 32'd0);
    if (disturb) chk(errs == 0, "R9", "stream under input changes", 32'(errs), 32'd0);
    @(negedge clk);
    chk(!wr_en, "R7", "no extra strobe", {31'd0, wr_en}, 32'd0);
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8", "done held while start high", {30'd0, busy, done}, 32'd1);
    start = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R8", "idle after release", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && wr_data == 32'd0, "R11", "in reset",
        {busy, done, wr_en, 29'd0} | wr_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en && wr_data == 32'd0, "R11", "after reset",
        {busy, done, wr_en, 29'd0} | wr_data, 32'd0);
    seed = 32'hDEAD_BEEF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!wr_en && !busy, "R6", "idle without start", {30'd0, busy, wr_en}, 32'd0);
    end
    run_seq(32'h3FA6_6666, 1'b1);
    run_seq(32'h0000_0000, 1'b0);
    run_seq(32'hFFFF_FFFF, 1'b0);
    run_seq(32'h8000_0000, 1'b0);
    run_seq(32'h0000_0001, 1'b0);
    run_seq(32'h7F80_0000, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule